// File: doc/BRIEF.md
# Multiple-Register Transfer Sequencer

This block carries out a block load or block store between a register file it owns and a simple memory port. A single start request names a set of registers through a one-hot-per-register list, a base register holding the memory address, the direction of transfer (load or store), whether addresses climb or fall from the base, whether the first address is offset from the base before use, and whether the base should be left pointing past the block afterwards. The sequencer then issues one memory access per listed register, lowest register index at the lowest address, one word per access.

Two rules set the timing and the recovery. The updated base is committed at a fixed point, the end of the first transfer cycle. So a store that sends the base as its first word sends the old value, while a store that sends the base later sends the new one. A load that fetches the base always overrides the committed base. An abort reported by memory against a store does not stop the block: all words go out and the trap is raised with completion. An abort against a load freezes the register file from that word on and puts the base back at its defined value. Because the program counter has the highest index, it always comes last and so survives any load abort.

The register file also has a plain read port and a plain write port for the surrounding core. The write port works only while the sequencer is idle.

Top module: `multi_xfer_seq`

## Requirements
- R1: `busy` rises in the cycle after an accepted start (start high while idle), stays high up to and including the `done` cycle and is low in the next cycle. A start that arrives while `busy` is high is ignored.
- R2: Registers are accessed in ascending index order, one word (4 bytes) apart. The first address is base, base+4, base-4n+4 or base-4n for up/post, up/pre, down/post and down/pre, where n is the number of list bits set. `memWe` is 1 for a store and 0 for a load.
- R3: With `memValid` high on every request, `done` is a one-cycle pulse n+1 cycles after the start cycle. A load that writes register 15 finishes 2 cycles later, at n+3.
- R4: With `writeBack` set, the base register ends at base+4n (up) or base-4n (down), committed at the end of the first transfer cycle. With it clear, the base is unchanged by a store.
- R5: A store that sends the base as its first word sends the original base value. One that sends it second or later sends the updated value if `writeBack` is set.
- R6: A load whose list includes the base leaves the loaded word in the base, even when `writeBack` is set.
- R7: After a store abort, every listed word is still sent. The only register change is the write-back, and `abortTrap` is high together with `done`.
- R8: After a load abort, the aborting word and all later words are not written, including register 15. Earlier loaded words remain, no fetch cycles are added, and `abortTrap` is high with `done`.
- R9: After a load abort, the base register holds the updated base if `writeBack` is set and the original base otherwise, even if the base had been loaded earlier in the sequence.
- R10: An empty register list gives `done` in the cycle after the start cycle, with no memory request and no change to any register.
- R11: While `memValid` is low, `memReq` stays high with `memAddr` and `memWdata` unchanged. The sequence continues only on `memValid`.
- R12: The register file write port (`rfWrEn`) takes effect while idle and is ignored while `busy` is high. `rfRdData` returns the register selected by `rfRdIdx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, taken only while idle |
| regList | input | 16 | One bit per register to transfer |
| baseIdx | input | 4 | Index of the base register |
| isLoad | input | 1 | 1 = load into registers, 0 = store to memory |
| up | input | 1 | 1 = addresses above base, 0 = below |
| preIndex | input | 1 | Offset base by one word before the first access |
| writeBack | input | 1 | Commit the updated base |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| abortTrap | output | 1 | Operation saw an abort; valid with done |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write access |
| memAddr | output | 32 | Byte address of the access |
| memWdata | output | 32 | Store data |
| memRdata | input | 32 | Load data, valid with memValid |
| memValid | input | 1 | Access completes this cycle |
| memAbort | input | 1 | Access aborted; sampled with memValid |
| rfWrEn | input | 1 | Core write strobe into the register file |
| rfWrIdx | input | 4 | Core write index |
| rfWrData | input | 32 | Core write data |
| rfRdIdx | input | 4 | Core read index |
| rfRdData | output | 32 | Core read data |

## Verification
The first transfer cycle is where two register-file writes can coincide: the base write-back commit and the first completed load, or the first store read of the base. The bench provokes this with a load whose first listed register is the base and write-back enabled, and with stores that send the base first or later, with and without stall cycles. It judges the outcome from the scoreboarded store data and from base contents read back afterwards. A second coincidence, a load abort restore against an earlier load into the base, is provoked by aborting the word after the base and checking that the restore wins.

// File: rtl/mxs_pkg.sv
`timescale 1ns/1ps
package mxs_pkg;

  // Strobes from the sequencing control into the datapath
  typedef struct packed {
    logic latch;        // capture operands of an accepted start
    logic advance;      // a transfer completed, move to next register
    logic commitBase;   // first transfer cycle: write-back point
    logic loadWrite;    // write loaded word into register file
    logic restoreBase;  // load abort: put base back
  } seqStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XFER,
    ST_WRAP,
    ST_FETCH1,
    ST_FETCH2
  } seqState_t;

endpackage

// File: rtl/mxs_control.sv
`timescale 1ns/1ps
module mxs_control
  import mxs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       listEmpty,
  input  logic       isLoad,
  input  logic       memValid,
  input  logic       memAbort,
  input  logic       lastXfer,
  input  logic       pcInList,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       abortTrap,
  output logic       memReq,
  output logic       memWe
);

  seqState_t state;
  logic      isLoadQ;
  logic      abortQ;
  logic      firstQ;
  logic      needFetch;

  assign needFetch = isLoadQ && pcInList && !abortQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      isLoadQ <= 1'b0;
      abortQ  <= 1'b0;
      firstQ  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            isLoadQ <= isLoad;
            abortQ  <= 1'b0;
            firstQ  <= 1'b1;
            state   <= listEmpty ? ST_WRAP : ST_XFER;
          end
        end
        ST_XFER: begin
          firstQ <= 1'b0;
          if (memValid) begin
            if (memAbort) abortQ <= 1'b1;
            if (lastXfer) state <= ST_WRAP;
          end
        end
        ST_WRAP:   state <= needFetch ? ST_FETCH1 : ST_IDLE;
        ST_FETCH1: state <= ST_FETCH2;
        ST_FETCH2: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe             = '0;
    strobe.latch       = (state == ST_IDLE) && start;
    strobe.advance     = (state == ST_XFER) && memValid;
    strobe.commitBase  = (state == ST_XFER) && firstQ;
    strobe.loadWrite   = (state == ST_XFER) && memValid && isLoadQ && !memAbort && !abortQ;
    strobe.restoreBase = (state == ST_WRAP) && isLoadQ && abortQ;
  end

  assign busy      = (state != ST_IDLE);
  assign done      = ((state == ST_WRAP) && !needFetch) || (state == ST_FETCH2);
  assign abortTrap = done && abortQ;
  assign memReq    = (state == ST_XFER);
  assign memWe     = !isLoadQ;

endmodule

// File: rtl/mxs_datapath.sv
`timescale 1ns/1ps
module mxs_datapath
  import mxs_pkg::*;
#(
  parameter int NUM_REGS   = 16,
  parameter int DATA_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int IDX_W      = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic                busy,
  input  logic [NUM_REGS-1:0] regList,
  input  logic [IDX_W-1:0]    baseIdx,
  input  logic                up,
  input  logic                preIndex,
  input  logic                writeBack,
  input  logic [DATA_W-1:0]   memRdata,
  input  logic                rfWrEn,
  input  logic [IDX_W-1:0]    rfWrIdx,
  input  logic [DATA_W-1:0]   rfWrData,
  input  logic [IDX_W-1:0]    rfRdIdx,
  output logic [DATA_W-1:0]   rfRdData,
  output logic [DATA_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic                lastXfer,
  output logic                pcInList
);

  localparam int                WORD_SHIFT = $clog2(WORD_BYTES);
  localparam logic [DATA_W-1:0] WORD       = DATA_W'(WORD_BYTES);
  localparam int                PC_IDX     = NUM_REGS - 1;

  logic [DATA_W-1:0]   regs [NUM_REGS];
  logic [NUM_REGS-1:0] listQ, maskQ;
  logic [DATA_W-1:0]   addrQ, origBaseQ, newBaseQ;
  logic [IDX_W-1:0]    baseIdxQ;
  logic                wbQ;

  logic [IDX_W:0]      setCount;
  logic [DATA_W-1:0]   baseVal, span, startAddr, newBase;
  logic [IDX_W-1:0]    curIdx;

  always_comb begin
    setCount = '0;
    for (int i = 0; i < NUM_REGS; i++) setCount = setCount + (IDX_W+1)'(regList[i]);
  end

  assign baseVal = regs[baseIdx];
  assign span    = DATA_W'(setCount) << WORD_SHIFT;
  assign newBase = up ? baseVal + span : baseVal - span;

  always_comb begin
    if (up) startAddr = preIndex ? baseVal + WORD : baseVal;
    else    startAddr = preIndex ? baseVal - span : baseVal - span + WORD;
  end

  // lowest remaining register is the next one to move
  always_comb begin
    curIdx = '0;
    for (int i = NUM_REGS - 1; i >= 0; i--) if (maskQ[i]) curIdx = IDX_W'(i);
  end

  assign lastXfer = ((maskQ & (maskQ - 1'b1)) == '0);
  assign pcInList = listQ[PC_IDX];
  assign memAddr  = addrQ;
  // base sent as the first word leaves before the commit point
  assign memWdata = ((curIdx == baseIdxQ) && (maskQ == listQ)) ? origBaseQ : regs[curIdx];
  assign rfRdData = regs[rfRdIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      listQ     <= '0;
      maskQ     <= '0;
      addrQ     <= '0;
      origBaseQ <= '0;
      newBaseQ  <= '0;
      baseIdxQ  <= '0;
      wbQ       <= 1'b0;
    end else if (strobe.latch) begin
      listQ     <= regList;
      maskQ     <= regList;
      addrQ     <= startAddr;
      origBaseQ <= baseVal;
      newBaseQ  <= newBase;
      baseIdxQ  <= baseIdx;
      wbQ       <= writeBack;
    end else if (strobe.advance) begin
      maskQ <= maskQ & (maskQ - 1'b1);
      addrQ <= addrQ + WORD;
    end
  end

  // later statements win on the same index: load beats commit, restore beats load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else begin
      if (rfWrEn && !busy)                 regs[rfWrIdx]  <= rfWrData;
      if (strobe.commitBase && wbQ)        regs[baseIdxQ] <= newBaseQ;
      if (strobe.loadWrite)                regs[curIdx]   <= memRdata;
      if (strobe.restoreBase)              regs[baseIdxQ] <= wbQ ? newBaseQ : origBaseQ;
    end
  end

endmodule

// File: rtl/multi_xfer_seq.sv
`timescale 1ns/1ps
module multi_xfer_seq
  import mxs_pkg::*;
#(
  parameter int NUM_REGS   = 16,
  parameter int DATA_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int IDX_W      = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [NUM_REGS-1:0] regList,
  input  logic [IDX_W-1:0]    baseIdx,
  input  logic                isLoad,
  input  logic                up,
  input  logic                preIndex,
  input  logic                writeBack,
  output logic                busy,
  output logic                done,
  output logic                abortTrap,
  output logic                memReq,
  output logic                memWe,
  output logic [DATA_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  input  logic [DATA_W-1:0]   memRdata,
  input  logic                memValid,
  input  logic                memAbort,
  input  logic                rfWrEn,
  input  logic [IDX_W-1:0]    rfWrIdx,
  input  logic [DATA_W-1:0]   rfWrData,
  input  logic [IDX_W-1:0]    rfRdIdx,
  output logic [DATA_W-1:0]   rfRdData
);

  seqStrobe_t strobe;
  logic       lastXfer, pcInList;

  mxs_control u_ctrl (
    .clk, .rstN, .start,
    .listEmpty (regList == '0),
    .isLoad, .memValid, .memAbort, .lastXfer, .pcInList,
    .strobe, .busy, .done, .abortTrap, .memReq, .memWe
  );

  mxs_datapath #(
    .NUM_REGS (NUM_REGS), .DATA_W (DATA_W),
    .WORD_BYTES (WORD_BYTES), .IDX_W (IDX_W)
  ) u_dp (
    .clk, .rstN, .strobe, .busy, .regList, .baseIdx, .up, .preIndex,
    .writeBack, .memRdata, .rfWrEn, .rfWrIdx, .rfWrData, .rfRdIdx,
    .rfRdData, .memAddr, .memWdata, .lastXfer, .pcInList
  );

endmodule

// File: rtl/mxs_checker.sv
`timescale 1ns/1ps
module mxs_checker #(
  parameter int DATA_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              abortTrap,
  input logic              memReq,
  input logic              memValid,
  input logic [DATA_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata
);

  // R1
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  // R1
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  // R1
  busy_ends_on_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(done));

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  trap_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortTrap |-> done);

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memValid) |=> (!memReq || (memAddr == $past(memAddr) + DATA_W'(WORD_BYTES))));

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> (memReq && $stable(memAddr) && $stable(memWdata)));

endmodule

bind multi_xfer_seq mxs_checker #(.DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES)) u_chk (
  .clk (clk), .rstN (rstN), .busy (busy), .done (done), .abortTrap (abortTrap),
  .memReq (memReq), .memValid (memValid), .memAddr (memAddr), .memWdata (memWdata)
);

// File: tb/multi_xfer_seq_tb.sv
`timescale 1ns/1ps
module multi_xfer_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] regList = '0;
  logic [3:0]  baseIdx = '0;
  logic        isLoad = 1'b0, up = 1'b0, preIndex = 1'b0, writeBack = 1'b0;
  logic        busy, done, abortTrap, memReq, memWe;
  logic [31:0] memAddr, memWdata, memRdata;
  logic        memValid, memAbort;
  logic        rfWrEn = 1'b0;
  logic [3:0]  rfWrIdx = '0, rfRdIdx = '0;
  logic [31:0] rfWrData = '0;
  logic [31:0] rfRdData;

  logic        stallMode = 1'b0, stallNow = 1'b0;
  logic        abortEn = 1'b0;
  logic [31:0] abortAddr = '0;

  int testCnt = 0, failCnt = 0;
  logic [31:0] mdl [16];

  logic [31:0] expAddr [$];
  logic        expWe   [$];
  logic [31:0] expData [$];
  string       expTag  [$];

  always #2.5 clk = ~clk;

  multi_xfer_seq u_dut (
    .clk, .rstN, .start, .regList, .baseIdx, .isLoad, .up, .preIndex, .writeBack,
    .busy, .done, .abortTrap, .memReq, .memWe, .memAddr, .memWdata, .memRdata,
    .memValid, .memAbort, .rfWrEn, .rfWrIdx, .rfWrData, .rfRdIdx, .rfRdData
  );

  function automatic logic [31:0] rdFn(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h0F0F_3C00;
  endfunction

  // memory responder
  always @(posedge clk) stallNow <= stallMode ? !stallNow : 1'b0;
  assign memValid = memReq && !stallNow;
  assign memRdata = memReq ? rdFn(memAddr) : 32'h0;
  assign memAbort = memReq && abortEn && (memAddr == abortAddr);

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected transfers as the design completes them
  logic        prevStall = 1'b0;
  logic [31:0] prevAddr = '0, prevData = '0;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall) begin
        check("R11", "request held", {31'b0, memReq}, 32'd1);
        check("R11", "addr held", memAddr, prevAddr);
        check("R11", "data held", memWdata, prevData);
      end
      prevStall = memReq && !memValid;
      prevAddr  = memAddr;
      prevData  = memWdata;
      if (memReq && memValid) begin
        if (expAddr.size() == 0) begin
          check("R10", "unexpected transfer addr", memAddr, 32'hFFFF_FFFF);
        end else begin
          automatic logic [31:0] ea = expAddr.pop_front();
          automatic logic        ew = expWe.pop_front();
          automatic logic [31:0] ed = expData.pop_front();
          automatic string       et = expTag.pop_front();
          check("R2", "address", memAddr, ea);
          check("R2", "write enable", {31'b0, memWe}, {31'b0, ew});
          if (ew) check(et, "store data", memWdata, ed);
        end
      end
    end
  end

  task automatic rfWrite(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    rfWrEn = 1'b1; rfWrIdx = idx; rfWrData = val;
    @(negedge clk);
    rfWrEn = 1'b0;
    mdl[idx] = val;
  endtask

  task automatic rfCheck(input logic [3:0] idx, input logic [31:0] exp, input string tag);
    rfRdIdx = idx;
    #0.5;
    check(tag, $sformatf("reg %0d", idx), rfRdData, exp);
  endtask

  // driver: computes the expected outcome, pushes transfers, runs the operation
  task automatic runOp(input logic [15:0] lst, input logic [3:0] b, input logic ld,
                       input logic u, input logic pre, input logic wb,
                       input logic abE, input logic [31:0] abA, input logic stl,
                       input logic poke, input logic [3:0] pokeIdx, input string tag);
    logic [31:0] nm [16];
    logic [31:0] orig, nb, a, d, span;
    int n, cyc, expCyc;
    logic first, aborted, pcLoaded;
    n = $countones(lst);
    for (int i = 0; i < 16; i++) nm[i] = mdl[i];
    orig = mdl[b];
    span = 32'(n) * 32'd4;
    nb = u ? orig + span : orig - span;
    a = u ? (pre ? orig + 32'd4 : orig) : (pre ? orig - span : orig - span + 32'd4);
    first = 1'b1; aborted = 1'b0; pcLoaded = 1'b0;
    if (wb) nm[b] = nb;
    for (int i = 0; i < 16; i++) begin
      if (lst[i]) begin
        if (abE && a == abA) aborted = 1'b1;
        if (ld) begin
          d = rdFn(a);
          if (!aborted) begin nm[i] = d; if (i == 15) pcLoaded = 1'b1; end
        end else begin
          d = (i == int'(b)) ? (first ? orig : (wb ? nb : orig)) : mdl[i];
        end
        expAddr.push_back(a); expWe.push_back(!ld); expData.push_back(d); expTag.push_back(tag);
        first = 1'b0;
        a = a + 32'd4;
      end
    end
    if (ld && aborted) nm[b] = wb ? nb : orig;
    expCyc = (n == 0) ? 1 : n + 1 + ((ld && pcLoaded) ? 2 : 0);

    abortEn = abE; abortAddr = abA; stallMode = stl;
    @(negedge clk);
    regList = lst; baseIdx = b; isLoad = ld; up = u; preIndex = pre; writeBack = wb;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; cyc = 1;
    while (!done && cyc < 300) begin
      if (poke && cyc == 1) begin
        start = 1'b1; regList = 16'hFFFF; rfWrEn = 1'b1; rfWrIdx = pokeIdx; rfWrData = 32'hDEAD_BEEF;
      end else begin
        start = 1'b0; rfWrEn = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; rfWrEn = 1'b0;
    check("R3", "done seen", {31'b0, done}, 32'd1);
    if (!stl) check("R3", "cycles to done", 32'(cyc), 32'(expCyc));
    check("R1", "busy at done", {31'b0, busy}, 32'd1);
    check(aborted ? (ld ? "R8" : "R7") : tag, "abort trap", {31'b0, abortTrap}, {31'b0, aborted});
    @(negedge clk);
    check("R1", "busy after done", {31'b0, busy}, 32'd0);
    check("R2", "transfers left", 32'(expAddr.size()), 32'd0);
    expAddr.delete(); expWe.delete(); expData.delete(); expTag.delete();
    stallMode = 1'b0; abortEn = 1'b0;
    for (int i = 0; i < 16; i++) begin
      mdl[i] = nm[i];
      rfCheck(4'(i), mdl[i], tag);
    end
  endtask

  initial begin
    #500000;
    failCnt++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check("R1", "busy after reset", {31'b0, busy}, 32'd0);
    check("R3", "done after reset", {31'b0, done}, 32'd0);
    check("R10", "memReq after reset", {31'b0, memReq}, 32'd0);
    rfCheck(4'd3, 32'h0, "R12");

    // R12: preload through the idle write port
    for (int i = 0; i < 16; i++) rfWrite(4'(i), 32'h1000_0000 + 32'(i) * 32'h0000_0130);
    rfWrite(4'd13, 32'h0000_8000);
    rfWrite(4'd4, 32'h0000_4000);
    rfWrite(4'd10, 32'h0000_A000);
    rfWrite(4'd2, 32'h0000_2000);
    rfWrite(4'd5, 32'h0000_5000);
    rfWrite(4'd6, 32'h0000_6000);
    for (int i = 0; i < 16; i++) rfCheck(4'(i), mdl[i], "R12");

    // R4 R5: store, base first, up post, write-back
    runOp(16'h0070, 4'd4, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 4'd0, "R4");
    // R5: store, base second, down pre, write-back
    runOp(16'h0C01, 4'd10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 4'd0, "R5");
    // R1 R12: load up pre, no write-back, start and write poked while busy
    runOp(16'h00A6, 4'd13, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 4'd0, "R12");
    // R6: load with base first in list and write-back in the same cycle
    runOp(16'h000C, 4'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 4'd0, "R6");
    // R3: load including register 15
    runOp(16'h8003, 4'd13, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 4'd0, "R3");
    // R8: load abort on third word, base loaded first, register 15 kept
    runOp(16'h80E0, 4'd5, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, mdl[5] + 32'd8, 1'b0, 1'b0, 4'd0, "R8");
    // R9: load abort without write-back, base loaded then restored
    runOp(16'h00C0, 4'd6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, mdl[6] + 32'd4, 1'b0, 1'b0, 4'd0, "R9");
    // R7: store abort on second word, down post, write-back
    runOp(16'h0F00, 4'd13, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, mdl[13] - 32'd8, 1'b0, 1'b0, 4'd0, "R7");
    // R10: empty list with write-back requested
    runOp(16'h0000, 4'd13, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 4'd0, "R10");
    // R11: stalled load, down pre, write-back
    runOp(16'h0318, 4'd13, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0, 1'b1, 1'b0, 4'd0, "R11");
    // R11: stalled store, base third
    runOp(16'h7001, 4'd13, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0, 1'b1, 1'b0, 4'd0, "R11");
    // R5: stalled store, base first, still sends original value
    runOp(16'hA000, 4'd13, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0, 1'b1, 1'b0, 4'd0, "R5");

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule